// File: doc/BRIEF.md
# Hypervisor Write-Trap Control Register Access Unit

This unit owns a 64-bit control word that a hypervisor uses to choose which guest writes of system registers are trapped. It also decides what happens to each system-register access aimed at that word. An access arrives as one request cycle carrying the five encoding fields, a direction flag, the write data and the processor context. That context is the current exception level, a three-bit nested-virtualisation pattern, whether the hypervisor level and the top (secure monitor) level are implemented, the monitor's fine-grained-trap enable, and a monitor undefined-priority flag.

One cycle later the unit answers with a registered response. The access either completes against the register, is undefined, traps to EL2, traps to EL3, or is redirected to a fixed offset in a memory page owned by the hypervisor. In the redirect case the unit emits the offset, the direction and the write data, and the caller performs the memory access. Requests whose encoding does not select the register get no response and change nothing. The register contents are driven out continuously so that the trap logic of the core can use them.

Top module: `fgw_trap_ctl_unit`

## Requirements
- R1: An access is selected only when op0=2'b11, op1=3'b100, CRn=4'b0001, CRm=4'b0001 and op2=3'b101. Any other encoding produces no response (rsp_valid stays 0) and leaves the register unchanged.
- R2: A selected access with level 0 is undefined (outcome code 1).
- R3: A selected access at level 1, with the hypervisor implemented and nv[2]=1 and nv[0]=1, is redirected (outcome code 4). The response asserts rsp_mem_req with offset 0x1C0, copies the direction to rsp_mem_write, and carries the write data on rsp_mem_wdata for writes (zero for reads). The register is not modified.
- R4: A selected access at level 1 with nv[0]=1 and nv[2]=0 traps to EL2 (outcome code 2) with class 0x18. At level 1, any pattern with nv[0]=0, or an absent hypervisor level, gives undefined.
- R5: A selected access at level 2, with the top level present and its trap enable at 0, traps to EL3 (outcome code 3) with class 0x18. If the undefined-priority input is 1, it is undefined instead.
- R6: A selected access at level 2 with the enable at 1 or the top level absent, and any selected access at level 3, completes (outcome code 0). A write stores the data and a read returns the register on rsp_rdata.
- R7: When the hypervisor level is not implemented, level-3 reads return zero and level-3 writes leave the register unchanged. Level-2 accesses are then undefined.
- R8: Bit positions 51, 46, 42, 40, 28, 26, 25, 21, 18, 15, 14, 10, 9 and 2 of the register always hold zero whatever is written.
- R9: Reset clears the register. Each selected request gets exactly one rsp_valid pulse in the following cycle. Trap outcomes carry class 0x18, all other outcomes carry class 0, and all response fields are zero when rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| req_level | input | 2 | Current exception level 0..3 |
| nv_bits | input | 3 | Nested-virtualisation pattern |
| hyp_present | input | 1 | Hypervisor level implemented |
| el3_present | input | 1 | Top level implemented |
| el3_fgt_en | input | 1 | Top level fine-grained-trap enable |
| el3_undef_prio | input | 1 | Undefined takes priority over the EL3 trap |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_outcome | output | 3 | 0 ok, 1 undefined, 2 trap EL2, 3 trap EL3, 4 redirect |
| rsp_class | output | 6 | Trap class (0x18 on traps) |
| rsp_rdata | output | 64 | Read data for completed reads |
| rsp_mem_req | output | 1 | Redirect to memory requested |
| rsp_mem_write | output | 1 | Direction of the redirected access |
| rsp_mem_offset | output | 12 | Memory offset of the redirected access |
| rsp_mem_wdata | output | 64 | Data for a redirected write |
| ctl_value | output | 64 | Current register contents |

## Verification
The bench sweeps all eight nested-virtualisation patterns at level 1. A decoder that tests only nv[0] would trap the 1x1 patterns instead of redirecting them, and one that tests only nv[2] would redirect 1x0. At level 2 it walks the monitor enable, presence and priority combinations. Swapping the priority would turn undefined into an EL3 trap, and a missed presence term would trap when the top level is absent. Writes of all ones and alternating patterns expose a wrong reserved mask. An encoding that differs in only one field must stay silent. An absent hypervisor level must leave the register untouched even for a level-3 write, which a design gating only the read path would get wrong.

// File: rtl/fgw_pkg.sv
package fgw_pkg;

  localparam int REG_W = 64;

  typedef enum logic [2:0] {
    OUT_OK       = 3'd0,
    OUT_UNDEF    = 3'd1,
    OUT_TRAP_EL2 = 3'd2,
    OUT_TRAP_EL3 = 3'd3,
    OUT_REDIR    = 3'd4
  } fgw_outcome_e;

  localparam logic [5:0] TRAP_CLASS = 6'h18;

  // Positions that never hold a control bit.
  function automatic logic [REG_W-1:0] fgw_rsvd_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[51] = 1'b1; m[46] = 1'b1; m[42] = 1'b1; m[40] = 1'b1;
    m[28] = 1'b1; m[26] = 1'b1; m[25] = 1'b1; m[21] = 1'b1;
    m[18] = 1'b1; m[15] = 1'b1; m[14] = 1'b1; m[10] = 1'b1;
    m[9]  = 1'b1; m[2]  = 1'b1;
    return m;
  endfunction

  // Access resolution by level and context.
  function automatic fgw_outcome_e fgw_resolve(
    input logic [1:0] lvl,
    input logic [2:0] nv,
    input logic       hyp,
    input logic       el3p,
    input logic       fgt_en,
    input logic       prio
  );
    fgw_outcome_e r;
    case (lvl)
      2'd0: r = OUT_UNDEF;
      2'd1: begin
        if (!hyp)                r = OUT_UNDEF;
        else if (nv[2] && nv[0]) r = OUT_REDIR;
        else if (nv[0])          r = OUT_TRAP_EL2;
        else                     r = OUT_UNDEF;
      end
      2'd2: begin
        if (!hyp)                r = OUT_UNDEF;
        else if (el3p && !fgt_en) r = prio ? OUT_UNDEF : OUT_TRAP_EL3;
        else                     r = OUT_OK;
      end
      default: r = OUT_OK;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fgw_sel_decode.sv
module fgw_sel_decode #(
  parameter int OP0_W = 2,
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter logic [OP0_W-1:0] SEL_OP0 = 2'b11,
  parameter logic [OP1_W-1:0] SEL_OP1 = 3'b100,
  parameter logic [CRN_W-1:0] SEL_CRN = 4'b0001,
  parameter logic [CRM_W-1:0] SEL_CRM = 4'b0001,
  parameter logic [OP2_W-1:0] SEL_OP2 = 3'b101
) (
  input  logic [OP0_W-1:0] op0,
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit
);
  localparam int NFIELD = 5;
  logic [NFIELD-1:0] fmatch;

  always_comb begin
    fmatch[0] = (op0 == SEL_OP0);
    fmatch[1] = (op1 == SEL_OP1);
    fmatch[2] = (crn == SEL_CRN);
    fmatch[3] = (crm == SEL_CRM);
    fmatch[4] = (op2 == SEL_OP2);
  end

  assign hit = &fmatch;
endmodule

// File: rtl/fgw_access_arbiter.sv
module fgw_access_arbiter
  import fgw_pkg::*;
(
  input  logic         req_valid,
  input  logic         sel_hit,
  input  logic         req_write,
  input  logic [1:0]   req_level,
  input  logic [2:0]   nv_bits,
  input  logic         hyp_present,
  input  logic         el3_present,
  input  logic         el3_fgt_en,
  input  logic         el3_undef_prio,
  output logic         accepted,
  output fgw_outcome_e outcome,
  output logic         commit_wr,
  output logic         read_ok
);
  assign accepted = req_valid && sel_hit;

  always_comb begin
    outcome = fgw_resolve(req_level, nv_bits, hyp_present,
                          el3_present, el3_fgt_en, el3_undef_prio);
  end

  // Only a completed access with the hypervisor level present touches the word.
  assign commit_wr = accepted && req_write  && (outcome == OUT_OK) && hyp_present;
  assign read_ok   = accepted && !req_write && (outcome == OUT_OK) && hyp_present;
endmodule

// File: rtl/fgw_ctl_store.sv
module fgw_ctl_store #(
  parameter int W = 64,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] KEEP = ~RSVD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata & KEEP;
  end
endmodule

// File: rtl/fgw_trap_ctl_unit.sv
module fgw_trap_ctl_unit
  import fgw_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter logic [OFF_W-1:0] REDIR_OFF = 12'h1C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_op0,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic [REG_W-1:0]  req_wdata,
  input  logic [1:0]        req_level,
  input  logic [2:0]        nv_bits,
  input  logic              hyp_present,
  input  logic              el3_present,
  input  logic              el3_fgt_en,
  input  logic              el3_undef_prio,
  output logic              rsp_valid,
  output logic [2:0]        rsp_outcome,
  output logic [5:0]        rsp_class,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic              rsp_mem_req,
  output logic              rsp_mem_write,
  output logic [OFF_W-1:0]  rsp_mem_offset,
  output logic [REG_W-1:0]  rsp_mem_wdata,
  output logic [REG_W-1:0]  ctl_value
);
  localparam logic [REG_W-1:0] RSVD_MASK = fgw_rsvd_mask();

  // Named internal events, visible to the bound checker.
  logic         sel_hit;
  logic         accepted;
  fgw_outcome_e outcome;
  logic         commit_wr;
  logic         read_ok;
  logic         is_trap;
  logic         is_redir;

  fgw_sel_decode u_dec (
    .op0 (req_op0),
    .op1 (req_op1),
    .crn (req_crn),
    .crm (req_crm),
    .op2 (req_op2),
    .hit (sel_hit)
  );

  fgw_access_arbiter u_arb (
    .req_valid      (req_valid),
    .sel_hit        (sel_hit),
    .req_write      (req_write),
    .req_level      (req_level),
    .nv_bits        (nv_bits),
    .hyp_present    (hyp_present),
    .el3_present    (el3_present),
    .el3_fgt_en     (el3_fgt_en),
    .el3_undef_prio (el3_undef_prio),
    .accepted       (accepted),
    .outcome        (outcome),
    .commit_wr      (commit_wr),
    .read_ok        (read_ok)
  );

  fgw_ctl_store #(.W(REG_W), .RSVD(RSVD_MASK)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (commit_wr),
    .wdata (req_wdata),
    .q     (ctl_value)
  );

  assign is_trap  = (outcome == OUT_TRAP_EL2) || (outcome == OUT_TRAP_EL3);
  assign is_redir = (outcome == OUT_REDIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_outcome    <= '0;
      rsp_class      <= '0;
      rsp_rdata      <= '0;
      rsp_mem_req    <= 1'b0;
      rsp_mem_write  <= 1'b0;
      rsp_mem_offset <= '0;
      rsp_mem_wdata  <= '0;
    end else if (accepted) begin
      rsp_valid      <= 1'b1;
      rsp_outcome    <= outcome;
      rsp_class      <= is_trap ? TRAP_CLASS : 6'h00;
      rsp_rdata      <= read_ok ? ctl_value : '0;
      rsp_mem_req    <= is_redir;
      rsp_mem_write  <= is_redir && req_write;
      rsp_mem_offset <= is_redir ? REDIR_OFF : '0;
      rsp_mem_wdata  <= (is_redir && req_write) ? req_wdata : '0;
    end else begin
      rsp_valid      <= 1'b0;
      rsp_outcome    <= '0;
      rsp_class      <= '0;
      rsp_rdata      <= '0;
      rsp_mem_req    <= 1'b0;
      rsp_mem_write  <= 1'b0;
      rsp_mem_offset <= '0;
      rsp_mem_wdata  <= '0;
    end
  end
endmodule

// File: rtl/fgw_trap_ctl_chk.sv
module fgw_trap_ctl_chk #(
  parameter int OFF_W = 12,
  parameter logic [OFF_W-1:0] REDIR_OFF = 12'h1C0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             sel_hit,
  input logic [1:0]       req_level,
  input logic             hyp_present,
  input logic             rsp_valid,
  input logic [2:0]       rsp_outcome,
  input logic [5:0]       rsp_class,
  input logic             rsp_mem_req,
  input logic [OFF_W-1:0] rsp_mem_offset,
  input logic [63:0]      ctl_value
);
  localparam logic [63:0] RSVD = fgw_pkg::fgw_rsvd_mask();

  // R1: unselected encodings get no response
  a_r1_no_rsp_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !sel_hit |=> !rsp_valid);

  // R2: level 0 is always undefined
  a_r2_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && sel_hit && req_level == 2'd0 |=> rsp_valid && rsp_outcome == 3'd1);

  // R3: redirect carries the fixed offset
  a_r3_redir_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_outcome == 3'd4 |-> rsp_mem_req && rsp_mem_offset == REDIR_OFF);

  // R3: any non-completing access leaves the word as it was
  a_r3_nonok_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_outcome != 3'd0 |-> $stable(ctl_value));

  // R5: traps carry class 0x18
  a_r5_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_outcome == 3'd2 || rsp_outcome == 3'd3) |-> rsp_class == 6'h18);

  // R7: absent hypervisor level: level-3 writes change nothing
  a_r7_no_hyp_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && sel_hit && !hyp_present && req_level == 2'd3 |=> $stable(ctl_value));

  // R8: reserved positions stay zero
  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_value & RSVD) == 64'd0);

  // R9: quiet response when not valid
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_outcome == 3'd0 && !rsp_mem_req && rsp_class == 6'd0);
endmodule

bind fgw_trap_ctl_unit fgw_trap_ctl_chk #(.OFF_W(OFF_W), .REDIR_OFF(REDIR_OFF)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .sel_hit        (sel_hit),
  .req_level      (req_level),
  .hyp_present    (hyp_present),
  .rsp_valid      (rsp_valid),
  .rsp_outcome    (rsp_outcome),
  .rsp_class      (rsp_class),
  .rsp_mem_req    (rsp_mem_req),
  .rsp_mem_offset (rsp_mem_offset),
  .ctl_value      (ctl_value)
);

// File: tb/fgw_trap_ctl_unit_test.sv
`timescale 1ns/1ps
module fgw_trap_ctl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_op0 = '0;
  logic [2:0]  req_op1 = '0;
  logic [3:0]  req_crn = '0, req_crm = '0;
  logic [2:0]  req_op2 = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  req_level = '0;
  logic [2:0]  nv_bits = '0;
  logic        hyp_present = 1'b1, el3_present = 1'b1, el3_fgt_en = 1'b1, el3_undef_prio = 1'b0;
  logic        rsp_valid, rsp_mem_req, rsp_mem_write;
  logic [2:0]  rsp_outcome;
  logic [5:0]  rsp_class;
  logic [63:0] rsp_rdata, rsp_mem_wdata, ctl_value;
  logic [11:0] rsp_mem_offset;

  always #2.5 clk = ~clk;

  fgw_trap_ctl_unit uut (.*);

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string drv_tag = "R9";

  // Reference model state
  logic [63:0] m_reg = '0;
  logic [63:0] rsvd;
  bit          e_valid, e_mreq, e_mwr;
  int          e_out;
  logic [5:0]  e_class;
  logic [63:0] e_rdata, e_mwdata;
  logic [11:0] e_off;
  string       e_tag;

  initial begin
    int pos[14] = '{2, 9, 10, 14, 15, 18, 21, 25, 26, 28, 40, 42, 46, 51};
    rsvd = '0;
    foreach (pos[i]) rsvd[pos[i]] = 1'b1;
  end

  always @(posedge clk) begin
    bit sel;
    e_tag = drv_tag;
    if (!rst_n) begin
      m_reg = '0; e_valid = 0; e_out = 0; e_class = 0; e_rdata = 0;
      e_mreq = 0; e_mwr = 0; e_off = 0; e_mwdata = 0;
    end else begin
      sel = req_op0 == 2'b11 && req_op1 == 3'b100 && req_crn == 4'd1 &&
            req_crm == 4'd1 && req_op2 == 3'b101;
      e_valid = req_valid && sel;
      e_out = 0; e_class = 0; e_rdata = 0; e_mreq = 0; e_mwr = 0; e_off = 0; e_mwdata = 0;
      if (e_valid) begin
        if (req_level == 0) e_out = 1;
        else if (req_level == 3) e_out = 0;
        else if (!hyp_present) e_out = 1;
        else if (req_level == 1) begin
          if (nv_bits[0] == 0) e_out = 1;
          else if (nv_bits[2]) e_out = 4;
          else e_out = 2;
        end else begin
          if (el3_present && !el3_fgt_en) e_out = el3_undef_prio ? 1 : 3;
          else e_out = 0;
        end
        if (e_out == 2 || e_out == 3) e_class = 6'h18;
        if (e_out == 4) begin
          e_mreq = 1; e_off = 12'h1C0; e_mwr = req_write;
          if (req_write) e_mwdata = req_wdata;
        end
        if (e_out == 0 && hyp_present) begin
          if (req_write) m_reg = req_wdata & ~rsvd;
          else e_rdata = m_reg;
        end
      end
    end
    #1;
    checks++;
    if (rsp_valid !== e_valid || rsp_outcome !== 3'(e_out) || rsp_class !== e_class ||
        rsp_rdata !== e_rdata || rsp_mem_req !== e_mreq || rsp_mem_write !== e_mwr ||
        rsp_mem_offset !== e_off || rsp_mem_wdata !== e_mwdata || ctl_value !== m_reg) begin
      errors++;
      $display("FAIL %s: valid %0b/%0b outcome %0d/%0d class %h/%h rdata %h/%h mreq %0b/%0b mwr %0b/%0b off %h/%h mwdata %h/%h reg %h/%h",
               e_tag, rsp_valid, e_valid, rsp_outcome, e_out, rsp_class, e_class,
               rsp_rdata, e_rdata, rsp_mem_req, e_mreq, rsp_mem_write, e_mwr,
               rsp_mem_offset, e_off, rsp_mem_wdata, e_mwdata, ctl_value, m_reg);
    end
  end

  task automatic acc(input string tag, input bit wr, input logic [1:0] lvl,
                     input logic [2:0] nv, input logic [63:0] d,
                     input bit hyp = 1, input bit el3p = 1, input bit fgt = 1, input bit prio = 0);
    @(negedge clk);
    drv_tag = tag;
    req_valid = 1; req_write = wr; req_level = lvl; nv_bits = nv; req_wdata = d;
    hyp_present = hyp; el3_present = el3p; el3_fgt_en = fgt; el3_undef_prio = prio;
    req_op0 = 2'b11; req_op1 = 3'b100; req_crn = 4'd1; req_crm = 4'd1; req_op2 = 3'b101;
    @(negedge clk);
    req_valid = 0; drv_tag = "R9";
  endtask

  task automatic miss(input string tag, input int field);
    @(negedge clk);
    drv_tag = tag;
    req_valid = 1; req_write = 1; req_level = 3; req_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    hyp_present = 1;
    req_op0 = 2'b11; req_op1 = 3'b100; req_crn = 4'd1; req_crm = 4'd1; req_op2 = 3'b101;
    case (field)
      0: req_op0 = 2'b10;
      1: req_op1 = 3'b000;
      2: req_crn = 4'd2;
      3: req_crm = 4'd0;
      default: req_op2 = 3'b100;
    endcase
    @(negedge clk);
    req_valid = 0; drv_tag = "R9";
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    acc("R9_reset_read", 0, 3, 0, 0);
    acc("R8_all_ones", 1, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    acc("R6_el3_read", 0, 3, 0, 0);
    acc("R6_el2_fgt_on", 1, 2, 0, 64'hA5A5_A5A5_5A5A_5A5A, 1, 1, 1, 0);
    acc("R6_el2_read", 0, 2, 0, 0, 1, 1, 1, 0);
    acc("R6_el2_no_el3", 1, 2, 0, 64'h5555_5555_AAAA_AAAA, 1, 0, 0, 0);
    acc("R5_trap_el3_wr", 1, 2, 0, 64'h1234, 1, 1, 0, 0);
    acc("R5_trap_el3_rd", 0, 2, 0, 0, 1, 1, 0, 0);
    acc("R5_prio_undef", 1, 2, 0, 64'h9999, 1, 1, 0, 1);
    acc("R2_el0_wr", 1, 0, 3'b101, 64'h7777);
    acc("R2_el0_rd", 0, 0, 3'b001, 0);
    for (int p = 0; p < 8; p++) begin
      acc((p[0] && p[2]) ? "R3_redir_wr" : "R4_el1_wr", 1, 1, 3'(p), 64'hDEAD_BEEF_0000_0000 | 64'(p));
      acc((p[0] && p[2]) ? "R3_redir_rd" : "R4_el1_rd", 0, 1, 3'(p), 0);
    end
    for (int f = 0; f < 5; f++) miss("R1_encoding_miss", f);
    acc("R6_readback", 0, 3, 0, 0);
    acc("R7_no_hyp_wr", 1, 3, 0, 64'h0F0F_0F0F_0F0F_0F0F, 0);
    acc("R7_no_hyp_rd", 0, 3, 0, 0, 0);
    acc("R7_no_hyp_el2", 1, 2, 0, 64'h1, 0);
    acc("R7_no_hyp_el1", 1, 1, 3'b101, 64'h1, 0);
    acc("R6_after_no_hyp", 0, 3, 0, 0);
    acc("R8_alt", 1, 3, 0, 64'hAAAA_AAAA_AAAA_AAAA);
    acc("R8_alt_rd", 0, 3, 0, 0);
    @(negedge clk); drv_tag = "R9_mid_reset"; rst_n = 0;
    @(negedge clk); rst_n = 1;
    acc("R9_post_reset_read", 0, 3, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: R9 run did not end, actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule